// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a programmable interval timer that advances on a 32768 Hz clock enable. Software loads a 16-bit period one byte at a time and sets a control byte. Each enable pulse moves an elapsed-tick counter forward while the timer runs. When the counter completes a full period, the block raises a sticky flag. Software clears that flag by writing a one to it.

In periodic mode the counter restarts from zero and keeps running. In one-shot mode the timer turns its own run bit off after the first expiry. To obtain a rate of 2^n Hz, software loads 0x8000 >> n as the period.

The interrupt line is the flag gated by an interrupt-enable bit. A write of any value to the count location restarts the elapsed count at zero. All registers sit behind a byte-wide port with a single write strobe and a combinational read path.

Top module: `ptmr_top`

## Requirements
- R1: After reset every readable location returns 0x00 and `irq` is low.
- R2: The period is written as two bytes: the low byte at address 1 and the high byte at address 2. Both bytes read back from the same addresses.
- R3: The elapsed count reads at address 3 (low byte) and address 4 (high byte). It increments by one on each cycle with `tick` high while the run bit (control bit 3) is set. It holds in every other cycle.
- R4: With a period N between 1 and 65535, the flag (control bit 1) sets on the cycle of the N-th counted tick after the count was zero, and the count returns to zero. A period of 0x4000 sets the flag every 16384 ticks.
- R5: A period of zero behaves as 65536 ticks.
- R6: With the mode bit (control bit 0) at 1 the timer keeps running after an expiry. With mode at 0 the expiry clears the run bit, and the count stays at zero.
- R7: Writing the control byte with bit 1 high clears the flag, and writing bit 1 low leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when the flag and the interrupt-enable bit (control bit 2) are both set. Bits 3, 2 and 0 of a control write are stored as written.
- R9: A write of any value to address 3 sets the count to zero, even when a tick arrives in the same cycle. That cycle produces no expiry.
- R10: Control bits 7 to 4 always read zero. Bit 7 is the watchdog busy status, which is never busy in this block. Writes to address 4 and to addresses 5 to 7 change no state, and those upper addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 32768 Hz count enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Timer interrupt request |

## Verification
The properties assume that the inputs are known after reset and that `tick` is a clock-enable: it may be high in any cycle, including two cycles in a row. The properties put no limit on how writes and ticks interleave, so the same-cycle collisions of a write with an expiry stay legal. The stimulus holds `tick` high on consecutive cycles to cover the long periods quickly, and uses alternating ticks for the sparse cases. It places ticks deliberately in the same cycle as a count clear and as a flag-clearing write.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    // register addresses (count follows the period bytes)
    localparam int A_CTRL = 0;
    localparam int A_RLD  = 1;

    // control byte bit positions
    localparam int B_MODE = 0;
    localparam int B_FLAG = 1;
    localparam int B_IEN  = 2;
    localparam int B_RUN  = 3;

    typedef struct packed {
        logic run;
        logic ien;
        logic flag;
        logic mode;
    } ctrl_t;
endpackage

// File: rtl/ptmr_ctrl_regs.sv
module ptmr_ctrl_regs
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int RLD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [RLD_W-1:0]  reload
);
    localparam int NB = RLD_W / DATA_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [RLD_W-1:0] reload;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_W'(A_CTRL)) begin
            st_d.ctrl.run  = wdata[B_RUN];
            st_d.ctrl.ien  = wdata[B_IEN];
            st_d.ctrl.mode = wdata[B_MODE];
            if (wdata[B_FLAG]) begin
                st_d.ctrl.flag = 1'b0;
            end
        end
        for (int i = 0; i < NB; i++) begin
            if (wr_en && addr == ADDR_W'(A_RLD + i)) begin
                st_d.reload[i*DATA_W +: DATA_W] = wdata;
            end
        end
        if (expire) begin
            st_d.ctrl.flag = 1'b1;
            if (!st_q.ctrl.mode) begin
                st_d.ctrl.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign reload = st_q.reload;
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] last_val;

    // reload of zero wraps to all ones, giving a full 2^CNT_W period
    assign last_val = reload - CNT_W'(1);
    assign expire   = tick && run && !clr && (st_q.cnt == last_val);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick && run) begin
            st_d.cnt = expire ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/ptmr_rd_mux.sv
module ptmr_rd_mux
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int RLD_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [RLD_W-1:0]  reload,
    input  logic [RLD_W-1:0]  count,
    output logic [DATA_W-1:0] rdata
);
    localparam int NB   = RLD_W / DATA_W;
    localparam int NREG = A_RLD + 2 * NB;

    logic [DATA_W-1:0] bank [NREG];

    assign bank[A_CTRL] = DATA_W'(ctrl);

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_bytes
            assign bank[A_RLD + g]      = reload[g*DATA_W +: DATA_W];
            assign bank[A_RLD + NB + g] = count[g*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = bank[i];
            end
        end
    end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int RLD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CLR_ADDR = A_RLD + RLD_W / DATA_W;

    ctrl_t            ctrl;
    logic [RLD_W-1:0] reload;
    logic [RLD_W-1:0] count;
    logic             expire;
    logic             clr;

    assign clr = wr_en && (addr == ADDR_W'(CLR_ADDR));

    ptmr_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RLD_W(RLD_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .expire (expire),
        .ctrl   (ctrl),
        .reload (reload)
    );

    ptmr_counter #(.CNT_W(RLD_W)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (ctrl.run),
        .clr    (clr),
        .reload (reload),
        .count  (count),
        .expire (expire)
    );

    ptmr_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RLD_W(RLD_W)) rd_i (
        .addr   (addr),
        .ctrl   (ctrl),
        .reload (reload),
        .count  (count),
        .rdata  (rdata)
    );

    assign irq = ctrl.flag & ctrl.ien;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int RLD_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input ctrl_t             ctrl,
    input logic [RLD_W-1:0]  count,
    input logic              expire
);
    localparam int CLR_ADDR = A_RLD + RLD_W / DATA_W;

    logic clr_w, wr_ctl;
    assign clr_w  = wr_en && addr == ADDR_W'(CLR_ADDR);
    assign wr_ctl = wr_en && addr == ADDR_W'(A_CTRL);

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> count == '0); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && ctrl.run && !clr_w && !expire |=> count == $past(count) + RLD_W'(1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || !ctrl.run) && !clr_w |=> $stable(count)); // R3
    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == '0); // R4
    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.flag) |-> $past(expire)); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl.flag); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && wdata[B_FLAG] && !expire |=> !ctrl.flag); // R7
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !ctrl.mode |=> !ctrl.run); // R6
    AST_PERIODIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ctrl.mode && !wr_ctl |=> ctrl.run); // R6
    AST_IEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctrl.ien == $past(wdata[B_IEN])); // R8
endmodule

bind ptmr_top ptmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RLD_W(RLD_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .ctrl   (ctrl),
    .count  (count),
    .expire (expire)
);

// File: tb/ptmr_top_tb.sv
`timescale 1ns/1ps
module ptmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;
    string cur = "R1";

    // behavioural reference state
    int m_run = 0, m_ien = 0, m_flag = 0, m_mode = 0, m_reload = 0, m_count = 0;

    always #2 clk = ~clk;

    ptmr_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    function automatic int m_rd(int a);
        case (a)
            0: return m_run * 8 + m_ien * 4 + m_flag * 2 + m_mode;
            1: return m_reload % 256;
            2: return m_reload / 256;
            3: return m_count % 256;
            4: return m_count / 256;
            default: return 0;
        endcase
    endfunction

    task automatic model_update(bit t, bit w, int a, int d);
        int  period;
        bit  clr, fire;
        int  old_mode;
        old_mode = m_mode;
        period = (m_reload == 0) ? 65536 : m_reload;
        clr  = w && a == 3;
        fire = t && m_run != 0 && !clr && (m_count + 1 == period);
        if (clr) m_count = 0;
        else if (t && m_run != 0) m_count = fire ? 0 : m_count + 1;
        if (w && a == 0) begin
            m_run  = (d >> 3) & 1;
            m_ien  = (d >> 2) & 1;
            m_mode = d & 1;
            if (((d >> 1) & 1) != 0) m_flag = 0;
        end
        if (w && a == 1) m_reload = (m_reload / 256) * 256 + (d & 255);
        if (w && a == 2) m_reload = (d & 255) * 256 + (m_reload % 256);
        if (fire) begin
            m_flag = 1;
            if (old_mode == 0) m_run = 0;
        end
    endtask

    task automatic step(bit t, bit w, int a, int d);
        tick  = t;
        wr_en = w;
        addr  = a[2:0];
        wdata = d[7:0];
        @(posedge clk);
        model_update(t, w, a, d);
        @(negedge clk);
        nchk++;
        if (int'(rdata) != m_rd(a) || int'(irq) != (m_flag & m_ien)) begin
            nerr++;
            $display("FAIL %s: rdata=%0h irq=%0b expected rdata=%0h irq=%0b",
                     cur, rdata, irq, m_rd(a), m_flag & m_ien);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rdchk(string tag, int a, int exp);
        step(1'b0, 1'b0, a, 0);
        chk(tag, int'(rdata), exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur = "R1";
        for (int a = 0; a < 5; a++) rdchk("R1 reset read", a, 0);
        chk("R1 irq", int'(irq), 0);

        cur = "R2";
        step(1'b0, 1'b1, 1, 8'h34);
        step(1'b0, 1'b1, 2, 8'h12);
        rdchk("R2 period low", 1, 8'h34);
        rdchk("R2 period high", 2, 8'h12);

        cur = "R10";
        step(1'b0, 1'b1, 0, 8'hF0);
        rdchk("R10 ctrl upper", 0, 0);
        step(1'b0, 1'b1, 4, 8'h55);
        step(1'b0, 1'b1, 7, 8'hAA);
        rdchk("R10 low kept", 1, 8'h34);
        rdchk("R10 high kept", 2, 8'h12);
        rdchk("R10 count kept", 4, 0);
        rdchk("R10 unmapped", 7, 0);

        cur = "R3";
        ticks(10);
        rdchk("R3 stopped", 3, 0);
        step(1'b0, 1'b1, 0, 8'h08);
        for (int i = 0; i < 14; i++) step(i % 2 == 0, 1'b0, 3, 0);
        rdchk("R3 sparse", 3, 7);
        repeat (10) step(1'b0, 1'b0, 3, 0);
        rdchk("R3 hold", 3, 7);

        cur = "R9";
        step(1'b1, 1'b1, 3, 8'h5A);
        rdchk("R9 clear low", 3, 0);
        rdchk("R9 clear high", 4, 0);

        cur = "R4";
        step(1'b0, 1'b1, 1, 8'h00);
        step(1'b0, 1'b1, 2, 8'h40);
        step(1'b0, 1'b1, 0, 8'h0D);
        step(1'b0, 1'b1, 3, 0);
        ticks(16383);
        rdchk("R4 before expiry", 0, 8'h0D);
        ticks(1);
        rdchk("R4 flag set", 0, 8'h0F);
        chk("R8 irq high", int'(irq), 1);
        rdchk("R4 count zero", 3, 0);

        cur = "R6";
        step(1'b0, 1'b1, 0, 8'h0F);
        rdchk("R7 cleared", 0, 8'h0D);
        ticks(16383);
        rdchk("R6 periodic pending", 0, 8'h0D);
        ticks(1);
        rdchk("R6 periodic again", 0, 8'h0F);

        cur = "R7";
        step(1'b0, 1'b1, 0, 8'h0D);
        rdchk("R7 zero keeps flag", 0, 8'h0F);
        step(1'b0, 1'b1, 1, 3);
        step(1'b0, 1'b1, 2, 0);
        step(1'b0, 1'b1, 3, 0);
        step(1'b0, 1'b1, 0, 8'h0F);
        ticks(2);
        step(1'b1, 1'b1, 0, 8'h0F);
        rdchk("R7 expiry wins", 0, 8'h0F);
        rdchk("R7 count zero", 3, 0);

        cur = "R8";
        step(1'b0, 1'b1, 0, 8'h09);
        rdchk("R8 ien off", 0, 8'h0B);
        chk("R8 irq low", int'(irq), 0);

        cur = "R6";
        step(1'b0, 1'b1, 1, 5);
        step(1'b0, 1'b1, 0, 8'h0A);
        rdchk("R6 one-shot armed", 0, 8'h08);
        step(1'b0, 1'b1, 3, 0);
        ticks(4);
        rdchk("R6 one-shot count", 3, 4);
        ticks(1);
        rdchk("R6 one-shot stopped", 0, 8'h02);
        ticks(5);
        rdchk("R6 one-shot idle", 3, 0);

        cur = "R5";
        step(1'b0, 1'b1, 1, 0);
        step(1'b0, 1'b1, 0, 8'h0F);
        step(1'b0, 1'b1, 3, 0);
        ticks(65535);
        rdchk("R5 no flag yet", 0, 8'h0D);
        rdchk("R5 count low", 3, 8'hFF);
        rdchk("R5 count high", 4, 8'hFF);
        ticks(1);
        rdchk("R5 flag at 65536", 0, 8'h0F);
        rdchk("R5 wrapped", 3, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule